// File: doc/BRIEF.md
# Iterative AES-128 Encryption Datapath

This block encrypts one 128-bit block at a time under AES-128, using a single round circuit that is reused for all ten rounds. A block enters with a one-cycle `start` strobe while the engine is idle. It is first combined with round key 0. The state register then circulates through the round circuit ten times, and on the last pass the column-mixing step is skipped. The ciphertext appears on `block_out`, and `done` pulses high for one cycle.

Each state byte has its own synchronous substitution table with one clock of latency, so sixteen lookups run in parallel. A round therefore takes two cycles: one to look up the substituted bytes, and one to rotate the rows, mix the columns, add the key and write the result back into the state register. The eleven round keys sit in a small register file that is written through the key port. Key expansion is done outside the block.

Top module: `aes_iter_core`

## Requirements
- R1: After a synchronous reset, `busy` and `done` are low and `block_out` is all zeros.
- R2: When `start` is high and `busy` is low at a rising edge, the block is accepted, and `busy` is high from the next cycle on.
- R3: For a block accepted at edge E, `done` is high for exactly one cycle, starting after edge E+20, and `busy` drops at that same edge.
- R4: When `done` is high, `block_out` equals the AES-128 encryption of the accepted block under round keys 0 to 10 from the key file. It gives 69c4e0d86a7b0430d8cdb78070b4c55a for key 000102…0f and plaintext 00112233…ff.
- R5: `start` is ignored while `busy` is high. Both the result and the timing of the running block are unchanged.
- R6: Byte k of a block (k = 0 to 15) is bits [127-8k -: 8]. Its state position is row k mod 4, column k div 4. Row r is rotated left by r byte positions. While idle, `block_out` holds the last result.
- R7: A write with `key_we` high stores `key_data` into entry `key_idx` for indices 0 to 10. Round r uses entry r. Writes to indices 11 to 15 have no effect.
- R8: Reset asserted during a run returns the block to idle at the next edge, and no `done` follows.
- R9: A `start` presented in the cycle in which `done` is high is accepted.
- R10: The tenth round applies substitution, row rotation and key addition but no column mixing. It gives 3925841d02dc09fbdc118597196a0b32 for key 2b7e151628aed2a6abf7158809cf4f3c and plaintext 3243f6a8885a308d313198a2e0370734.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| key_we | input | 1 | Round-key write enable |
| key_idx | input | 4 | Round-key entry to write |
| key_data | input | 128 | Round-key value to write |
| start | input | 1 | Accept `block_in` when idle |
| block_in | input | 128 | Plaintext block |
| busy | output | 1 | Encryption in progress |
| done | output | 1 | One-cycle result strobe |
| block_out | output | 128 | Ciphertext, held until the next start |

## Verification
Any error in the round counter or the phase sequence shows up at the ports as a `done` pulse that comes early or late, or never comes. A fault in the substitution, rotation, mixing or key selection leaves the timing intact but corrupts `block_out` completely by the done cycle, 20 cycles after acceptance. Because of diffusion, one wrong byte in any round changes almost every output byte. A cycle-accurate model compares `busy`, `done` and the held result every clock, so a fault in the handshake is caught in the first cycle it appears.

// File: rtl/aes_iter_pkg.sv
package aes_iter_pkg;
  localparam int BW    = 128;
  localparam int NBYTE = BW / 8;
  localparam int NR    = 10;
  localparam int NKEY  = NR + 1;
  localparam int KIW   = $clog2(NKEY);
  localparam int RW    = $clog2(NR + 1);
  localparam int RCYC  = 2;

  typedef logic [7:0]    byte_t;
  typedef logic [BW-1:0] blk_t;

  function automatic byte_t xt(input byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gmul(input byte_t a, input byte_t b);
    byte_t acc = '0;
    byte_t x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = xt(x);
    end
    return acc;
  endfunction

  function automatic byte_t rotl8(input byte_t v, input int n);
    logic [15:0] d = {v, v};
    return d[15-n -: 8];
  endfunction

  // inverse via x^254, then affine map
  function automatic byte_t sbox_calc(input byte_t x);
    byte_t x2, x3, x12, x15, x240, inv;
    x2   = gmul(x, x);
    x3   = gmul(x2, x);
    x12  = gmul(gmul(x3, x3), gmul(x3, x3));
    x15  = gmul(x12, x3);
    x240 = gmul(x15, x15);
    x240 = gmul(x240, x240);
    x240 = gmul(x240, x240);
    x240 = gmul(x240, x240);
    inv  = gmul(gmul(x240, x12), x2);
    return inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ 8'h63;
  endfunction

  function automatic byte_t get_byte(input blk_t b, input int k);
    return b[BW-1-8*k -: 8];
  endfunction

  function automatic blk_t shift_rows(input blk_t b);
    blk_t o = '0;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[BW-1-8*(4*c+r) -: 8] = get_byte(b, 4*((c+r)%4) + r);
    return o;
  endfunction

  function automatic blk_t mix_cols(input blk_t b);
    blk_t o = '0;
    byte_t a0, a1, a2, a3;
    for (int c = 0; c < 4; c++) begin
      a0 = get_byte(b, 4*c);
      a1 = get_byte(b, 4*c+1);
      a2 = get_byte(b, 4*c+2);
      a3 = get_byte(b, 4*c+3);
      o[BW-1-8*(4*c)   -: 8] = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
      o[BW-1-8*(4*c+1) -: 8] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
      o[BW-1-8*(4*c+2) -: 8] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
      o[BW-1-8*(4*c+3) -: 8] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
    end
    return o;
  endfunction
endpackage

// File: rtl/aes_sbox_rom.sv
module aes_sbox_rom
  import aes_iter_pkg::*;
(
  input  logic  clk,
  input  byte_t addr,
  output byte_t q
);
  // read-only table, one clock of latency
  always_ff @(posedge clk) q <= sbox_calc(addr);
endmodule

// File: rtl/aes_key_file.sv
module aes_key_file
  import aes_iter_pkg::*;
#(
  parameter int DEPTH = NKEY,
  parameter int IW    = 4
)(
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  blk_t          wr_data,
  input  logic [IW-1:0] rd_idx,
  output blk_t          rd_data
);
  blk_t mem [DEPTH];
  logic wr_hit;

  assign wr_hit = wr_en && (int'(wr_idx) < DEPTH);

  always_ff @(posedge clk)
    if (wr_hit) mem[wr_idx] <= wr_data;

  assign rd_data = (int'(rd_idx) < DEPTH) ? mem[rd_idx] : '0;
endmodule

// File: rtl/aes_round_step.sv
module aes_round_step
  import aes_iter_pkg::*;
(
  input  blk_t sub_blk,
  input  blk_t rkey,
  input  logic last,
  output blk_t nxt
);
  blk_t rot, mixed;
  assign rot   = shift_rows(sub_blk);
  assign mixed = mix_cols(rot);
  assign nxt   = (last ? rot : mixed) ^ rkey;
endmodule

// File: rtl/aes_iter_core.sv
module aes_iter_core
  import aes_iter_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         key_we,
  input  logic [3:0]   key_idx,
  input  logic [127:0] key_data,
  input  logic         start,
  input  logic [127:0] block_in,
  output logic         busy,
  output logic         done,
  output logic [127:0] block_out
);
  typedef enum logic [1:0] {ST_IDLE, ST_SUB, ST_MIX} fsm_t;

  fsm_t          fsm_q;
  logic [RW-1:0] round_q;
  blk_t          state_q, state_d, sub_q, round_nxt, rk_rd;
  logic [3:0]    rk_idx;
  logic          accept, last_rnd, load_state;

  assign accept     = start && (fsm_q == ST_IDLE);
  assign last_rnd   = (round_q == RW'(NR));
  assign load_state = accept || (fsm_q == ST_MIX);
  assign rk_idx     = (fsm_q == ST_IDLE) ? 4'd0 : 4'(round_q);

  aes_key_file #(.DEPTH(NKEY), .IW(4)) i_keys (
    .clk(clk), .wr_en(key_we), .wr_idx(key_idx), .wr_data(key_data),
    .rd_idx(rk_idx), .rd_data(rk_rd)
  );

  for (genvar g = 0; g < NBYTE; g++) begin : g_sbox
    aes_sbox_rom i_sb (
      .clk (clk),
      .addr(state_q[BW-1-8*g -: 8]),
      .q   (sub_q[BW-1-8*g -: 8])
    );
  end

  aes_round_step i_step (
    .sub_blk(sub_q), .rkey(rk_rd), .last(last_rnd), .nxt(round_nxt)
  );

  // feedback multiplexer in front of the state register
  assign state_d = accept ? (block_in ^ rk_rd) : round_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm_q   <= ST_IDLE;
      round_q <= '0;
      state_q <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load_state) state_q <= state_d;
      unique case (fsm_q)
        ST_IDLE: if (accept) begin
          round_q <= RW'(1);
          fsm_q   <= ST_SUB;
        end
        ST_SUB: fsm_q <= ST_MIX;
        ST_MIX: if (last_rnd) begin
          fsm_q <= ST_IDLE;
          done  <= 1'b1;
        end else begin
          round_q <= round_q + RW'(1);
          fsm_q   <= ST_SUB;
        end
        default: fsm_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (fsm_q != ST_IDLE);
  assign block_out = state_q;

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R3
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst) done |-> (!busy && $past(busy)));
  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy);
  // R8
  rst_idle_chk: assert property (@(posedge clk) rst |=> (!busy && !done));
  // R6
  hold_out_chk: assert property (@(posedge clk) disable iff (rst) (!busy && !start) |=> $stable(block_out));
  // R5
  phase_order_chk: assert property (@(posedge clk) disable iff (rst) (fsm_q == ST_SUB) |=> (fsm_q == ST_MIX && $stable(round_q)));
  // R10
  round_range_chk: assert property (@(posedge clk) disable iff (rst) busy |-> (round_q >= RW'(1) && round_q <= RW'(NR)));
endmodule

// File: tb/test_aes_iter_core.sv
module test_aes_iter_core;
  logic clk = 0, rst = 1, key_we = 0, start = 0;
  logic [3:0] key_idx = 0;
  logic [127:0] key_data = 0, block_in = 0;
  logic busy, done;
  logic [127:0] block_out;

  always #4 clk = ~clk;

  aes_iter_core i_aes_iter_core (
    .clk(clk), .rst(rst), .key_we(key_we), .key_idx(key_idx), .key_data(key_data),
    .start(start), .block_in(block_in), .busy(busy), .done(done), .block_out(block_out)
  );

  int total = 0, bad = 0, cyc = 0;
  bit live = 0;
  logic [7:0] tsb [256];
  logic [127:0] kmem [11];
  logic [127:0] xkeys [11];
  bit m_busy = 0, m_done = 0;
  int m_cnt = 0;
  logic [127:0] m_exp = 0, m_hold = 0;

  function automatic logic [7:0] m2(logic [7:0] a);
    return (a << 1) ^ (a[7] ? 8'h1b : 8'h00);
  endfunction
  function automatic logic [7:0] bmul(logic [7:0] a, logic [7:0] b);
    logic [7:0] r = 0;
    while (b != 0) begin
      if (b[0]) r ^= a;
      a = m2(a); b = b >> 1;
    end
    return r;
  endfunction

  initial begin
    for (int a = 0; a < 256; a++) begin
      logic [7:0] inv = 0, s;
      for (int b = 1; b < 256; b++) if (bmul(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
      for (int i = 0; i < 8; i++)
        s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ 8'h63 >> i & 1'b1;
      tsb[a] = s;
    end
    for (int i = 0; i < 11; i++) kmem[i] = 0;
  end

  function automatic void expand(logic [127:0] key);
    logic [31:0] w [44];
    logic [7:0] rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      logic [31:0] t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {tsb[t[31:24]], tsb[t[23:16]], tsb[t[15:8]], tsb[t[7:0]]} ^ {rc, 24'h0};
        rc = m2(rc);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) xkeys[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endfunction

  function automatic logic [127:0] ref_enc(logic [127:0] pt);
    logic [7:0] s [16], t [16];
    logic [127:0] o;
    for (int k = 0; k < 16; k++) s[k] = pt[127-8*k -: 8] ^ kmem[0][127-8*k -: 8];
    for (int rnd = 1; rnd <= 10; rnd++) begin
      for (int k = 0; k < 16; k++) t[k] = tsb[s[k]];
      for (int k = 0; k < 16; k++) s[k] = t[4*(((k/4)+(k%4))%4) + k%4];
      if (rnd < 10)
        for (int c = 0; c < 4; c++) begin
          logic [7:0] a0 = s[4*c], a1 = s[4*c+1], a2 = s[4*c+2], a3 = s[4*c+3];
          s[4*c]   = m2(a0) ^ m2(a1) ^ a1 ^ a2 ^ a3;
          s[4*c+1] = a0 ^ m2(a1) ^ m2(a2) ^ a2 ^ a3;
          s[4*c+2] = a0 ^ a1 ^ m2(a2) ^ m2(a3) ^ a3;
          s[4*c+3] = m2(a0) ^ a0 ^ a1 ^ a2 ^ m2(a3);
        end
      for (int k = 0; k < 16; k++) s[k] ^= kmem[rnd][127-8*k -: 8];
    end
    for (int k = 0; k < 16; k++) o[127-8*k -: 8] = s[k];
    return o;
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural cycle model
  always @(posedge clk) begin
    live <= 1;
    cyc++;
    if (rst) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_hold = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == 20) begin m_busy = 0; m_done = 1; m_hold = m_exp; end
      end else if (start) begin
        m_busy = 1; m_cnt = 0; m_exp = ref_enc(block_in);
      end
    end
    if (key_we && key_idx < 11) kmem[key_idx] = key_data;
  end

  always @(negedge clk) if (live) begin
    chk(busy == m_busy, "R2 busy", 128'(busy), 128'(m_busy));
    chk(done == m_done, "R3 done", 128'(done), 128'(m_done));
    if (m_done) chk(block_out == m_exp, "R4 result", block_out, m_exp);
    else if (!m_busy) chk(block_out == m_hold, "R6 hold", block_out, m_hold);
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic load_keys(logic [127:0] key);
    expand(key);
    for (int r = 0; r < 11; r++) begin
      key_we = 1; key_idx = 4'(r); key_data = xkeys[r];
      tick();
    end
    key_we = 0;
  endtask

  task automatic go(logic [127:0] pt);
    block_in = pt; start = 1; tick(); start = 0;
  endtask

  task automatic wait_done(output logic [127:0] ct);
    while (!done) tick();
    ct = block_out;
    tick();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 20000) begin
        total++; bad++;
        $display("FAIL watchdog act=%0d exp<20000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [127:0] ct, ct2;
    tick(3);
    // R1 reset state
    chk(!busy && !done && block_out == 0, "R1 reset", block_out, 0);
    rst = 0;
    tick();
    // R7 R4 first known vector
    load_keys(128'h000102030405060708090a0b0c0d0e0f);
    go(128'h00112233445566778899aabbccddeeff);
    wait_done(ct);
    chk(ct == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R4 vector1", ct, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    // R10 R6 second known vector
    load_keys(128'h2b7e151628aed2a6abf7158809cf4f3c);
    go(128'h3243f6a8885a308d313198a2e0370734);
    wait_done(ct);
    chk(ct == 128'h3925841d02dc09fbdc118597196a0b32, "R10 vector2", ct, 128'h3925841d02dc09fbdc118597196a0b32);
    tick(4);
    chk(block_out == ct, "R6 held", block_out, ct);
    // R5 start pulses while busy
    go(128'h0123456789abcdeffedcba9876543210);
    block_in = 128'hffff0000ffff0000ffff0000ffff0000;
    for (int i = 0; i < 6; i++) begin start = (i % 2 == 0); tick(3); end
    start = 0;
    wait_done(ct2);
    chk(ct2 == m_hold, "R5 ignore start", ct2, m_hold);
    // R7 out-of-range key writes ignored
    for (int i = 11; i < 16; i++) begin key_we = 1; key_idx = 4'(i); key_data = {4{32'hdeadbeef}}; tick(); end
    key_we = 0;
    go(128'h3243f6a8885a308d313198a2e0370734);
    wait_done(ct);
    chk(ct == 128'h3925841d02dc09fbdc118597196a0b32, "R7 idx>10 ignored", ct, 128'h3925841d02dc09fbdc118597196a0b32);
    // R9 back-to-back: start during done cycle
    go(128'h00000000000000000000000000000001);
    while (!done) tick();
    block_in = 128'h80000000000000000000000000000000; start = 1; tick(); start = 0;
    chk(busy, "R9 accept in done cycle", 128'(busy), 1);
    wait_done(ct);
    // R8 reset mid-run
    go(128'h1111222233334444555566667777888);
    tick(7);
    rst = 1; tick(); rst = 0;
    chk(!busy && !done && block_out == 0, "R8 mid reset", block_out, 0);
    tick(30);
    chk(!done, "R8 no done", 128'(done), 0);
    // several more patterns against the model
    for (int p = 0; p < 4; p++) begin
      go({4{32'h9e3779b9 * (p + 1)}});
      wait_done(ct);
    end
    tick(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule